// File: doc/BRIEF.md
# Bus Location Monitor Interrupter

This block listens to the address phase of a parallel system bus without ever taking part in it. Software points it at a 32-byte window by giving a base address aligned to 32 bytes. The window is split into four slots of eight bytes each. Any access to a slot, whether a read or a write, raises that slot's status flag. Boards use this to signal one another: writing or reading a watched slot interrupts every processor whose monitor covers it. The board that starts the access also sees its own hit, provided its monitor is set to the same window.

The block moves no data and never acknowledges the cycle, so the initiator must end the cycle by itself. Status flags stay set until software writes ones to clear them. A flag whose per-slot enable is set drives one of four interrupt outputs, and a 2-bit selector picks which output that is. The bus carries doubleword addresses only, so the port takes address bits from 3 upward.

Top module: `lm_monitor`

## Requirements
- R1: A hit needs bus address bits [ADDR_W-1:5] to equal `cfg_base`. Accesses to any other address leave status unchanged.
- R2: Address bits [4:3] pick the slot: 0 for byte offsets 0x00-0x07, 1 for 0x08-0x0F, 2 for 0x10-0x17 and 3 for 0x18-0x1F. A hit sets only that slot's bit in `stat`, which is `stat[slot]`.
- R3: Reads (`bus_write`=0) and writes (`bus_write`=1) both trigger a hit.
- R4: At most one bit of `irq_out` is high in any cycle.
- R5: While `cfg_mon_en` is 0, no access sets any status bit.
- R6: A hit is taken only in the first cycle that `bus_strobe` is high. If the strobe stays high after the status is cleared, the status stays clear.
- R7: Status bits are sticky. A cycle with `clr_valid` high clears exactly the bits that are set in `clr_mask`, and no other event clears a bit.
- R8: The interrupt is pending only while some bit of `stat & cfg_irq_en` is set. A slot whose enable bit is 0 sets its status but raises no interrupt.
- R9: While an interrupt is pending, `irq_out[cfg_line_sel]` is the only output bit that is high.
- R10: If a hit and a clear of the same bit fall in the same cycle, the bit ends up set.
- R11: After reset, `stat` and `irq_out` are all zero.
- R12: A hit is seen in `stat` one clock after the strobe first rises. A clear is seen one clock after `clr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_hi | input | ADDR_W-3 | Snooped bus address, bits [ADDR_W-1:3] |
| bus_strobe | input | 1 | Address strobe; high while a cycle is active |
| bus_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cfg_base | input | ADDR_W-5 | Window base, address bits [ADDR_W-1:5] |
| cfg_mon_en | input | 1 | Global monitor enable |
| cfg_irq_en | input | 4 | Per-slot interrupt enables |
| cfg_line_sel | input | 2 | Selects which interrupt output is driven |
| clr_valid | input | 1 | Clear strobe for the status bits |
| clr_mask | input | 4 | Write-one-to-clear mask |
| stat | output | 4 | Sticky per-slot status |
| irq_out | output | 4 | Interrupt lines; at most one is high |

## Verification
A wrong strobe-history flop shows up as a status bit that comes back straight after a clear while the strobe is still high. It can also show as a hit that never lands, and either error is visible one clock later. A wrong decode or base compare sets the wrong bit of `stat`, or sets a bit for an address outside the window, on the edge after the strobe rises. A bad status register or interrupt mux shows on `irq_out` in the same cycle that the status or the line select changes. So every internal fault reaches the ports within one clock.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int LOC_SEL_W     = 2;
  localparam int NUM_LOC       = 1 << LOC_SEL_W;
  localparam int LOC_SPAN_LOG2 = 3;
  localparam int WIN_LSB       = LOC_SPAN_LOG2 + LOC_SEL_W;
  typedef logic [NUM_LOC-1:0] loc_vec_t;
endpackage

// File: rtl/lm_strobe_edge.sv
module lm_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q, strobe_d;

  always_comb begin
    strobe_d = strobe;
    rise     = strobe & ~strobe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  // R6: a rise cannot repeat on consecutive cycles
  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lm_decode.sv
module lm_decode
  import lm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit TRIG_RD = 1'b1,
  parameter bit TRIG_WR = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:LOC_SPAN_LOG2] addr_hi,
  input  logic                       is_write,
  input  logic                       rise,
  input  logic [ADDR_W-1:WIN_LSB]    base,
  input  logic                       mon_en,
  output loc_vec_t                   set_vec
);
  logic win_match, kind_ok;
  logic [LOC_SEL_W-1:0] slot;

  always_comb begin
    win_match = (addr_hi[ADDR_W-1:WIN_LSB] == base);
    kind_ok   = is_write ? TRIG_WR : TRIG_RD;
    slot      = addr_hi[WIN_LSB-1:LOC_SPAN_LOG2];
    set_vec   = '0;
    if (rise && mon_en && win_match && kind_ok)
      set_vec[slot] = 1'b1;
  end

  // R2: one slot per access
  a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
  // R5: disabled monitor never produces hits
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (set_vec == '0));
endmodule

// File: rtl/lm_status.sv
module lm_status
  import lm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  loc_vec_t set_vec,
  input  logic     clr_valid,
  input  loc_vec_t clr_mask,
  output loc_vec_t stat
);
  loc_vec_t stat_q, stat_d;
  logic     upd_en;

  always_comb begin
    upd_en = clr_valid | (|set_vec);
    stat_d = stat_q;
    if (clr_valid) stat_d = stat_d & ~clr_mask;
    stat_d = stat_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= '0;
    else if (upd_en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  // R7: without a clear no bit drops
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R10: a hit always lands, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/lm_monitor.sv
module lm_monitor
  import lm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 4,
  parameter bit TRIG_RD   = 1'b1,
  parameter bit TRIG_WR   = 1'b1,
  localparam int LINE_SEL_W = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:LOC_SPAN_LOG2] bus_addr_hi,
  input  logic                        bus_strobe,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:WIN_LSB]     cfg_base,
  input  logic                        cfg_mon_en,
  input  logic [NUM_LOC-1:0]          cfg_irq_en,
  input  logic [LINE_SEL_W-1:0]       cfg_line_sel,
  input  logic                        clr_valid,
  input  logic [NUM_LOC-1:0]          clr_mask,
  output logic [NUM_LOC-1:0]          stat,
  output logic [NUM_LINES-1:0]        irq_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       rise, pending;
  loc_vec_t   set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lm_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_int_n), .strobe(bus_strobe), .rise(rise)
  );

  lm_decode #(.ADDR_W(ADDR_W), .TRIG_RD(TRIG_RD), .TRIG_WR(TRIG_WR)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .addr_hi(bus_addr_hi), .is_write(bus_write),
    .rise(rise), .base(cfg_base), .mon_en(cfg_mon_en), .set_vec(set_vec)
  );

  lm_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .set_vec(set_vec),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .stat(stat)
  );

  assign pending = |(stat & cfg_irq_en);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign irq_out[g] = pending && (cfg_line_sel == LINE_SEL_W'(g));
  end

  // R4: one line at most
  a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(irq_out));
  // R8: an interrupt needs an enabled status bit
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|irq_out) |-> (|(stat & cfg_irq_en)));
  // R9: pending interrupt drives the selected line
  a_r9_line_sel: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(stat & cfg_irq_en)) |-> irq_out[cfg_line_sel]);
endmodule

// File: tb/tb_lm_monitor.sv
module tb_lm_monitor;
  localparam int ADDR_W = 32;
  localparam logic [31:0] BASE = 32'h8000_1240;

  logic clk = 1'b0;
  logic rst_n;
  logic [ADDR_W-1:3] bus_addr_hi;
  logic bus_strobe, bus_write;
  logic [ADDR_W-1:5] cfg_base;
  logic cfg_mon_en;
  logic [3:0] cfg_irq_en;
  logic [1:0] cfg_line_sel;
  logic clr_valid;
  logic [3:0] clr_mask;
  logic [3:0] stat;
  logic [3:0] irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lm_monitor dut (
    .clk(clk), .rst_n(rst_n), .bus_addr_hi(bus_addr_hi), .bus_strobe(bus_strobe),
    .bus_write(bus_write), .cfg_base(cfg_base), .cfg_mon_en(cfg_mon_en),
    .cfg_irq_en(cfg_irq_en), .cfg_line_sel(cfg_line_sel), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .stat(stat), .irq_out(irq_out)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] addr, input logic wr);
    @(negedge clk);
    bus_addr_hi = addr[31:3]; bus_write = wr; bus_strobe = 1'b1;
    @(negedge clk);
    bus_strobe = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    clr_valid = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset;
    check(stat, 4'b0000, "R11 stat");
    check(irq_out, 4'b0000, "R11 irq");
  endtask

  task automatic t_decode;
    access(BASE + 32'h05, 1'b1); check(stat, 4'b0001, "R2 slot0 / R12");
    access(BASE + 32'h0F, 1'b1); check(stat, 4'b0011, "R2 slot1");
    access(BASE + 32'h10, 1'b1); check(stat, 4'b0111, "R2 slot2");
    access(BASE + 32'h1C, 1'b1); check(stat, 4'b1111, "R2 slot3");
    clear(4'hF);                 check(stat, 4'b0000, "R7 clear all / R12");
  endtask

  task automatic t_window;
    access(BASE + 32'h20, 1'b1); check(stat, 4'b0000, "R1 above window");
    access(BASE - 32'h8, 1'b0);  check(stat, 4'b0000, "R1 below window");
    access(BASE ^ 32'h4000_0000, 1'b1); check(stat, 4'b0000, "R1 high bit differs");
  endtask

  task automatic t_rw;
    access(BASE + 32'h08, 1'b0); check(stat, 4'b0010, "R3 read hit");
    access(BASE + 32'h18, 1'b1); check(stat, 4'b1010, "R3 write hit");
    clear(4'hF);
  endtask

  task automatic t_enable;
    cfg_mon_en = 1'b0;
    access(BASE + 32'h00, 1'b1); check(stat, 4'b0000, "R5 disabled");
    cfg_mon_en = 1'b1;
  endtask

  task automatic t_edge;
    @(negedge clk);
    bus_addr_hi = BASE[31:3] + 29'd1; bus_write = 1'b1; bus_strobe = 1'b1;
    @(negedge clk); check(stat, 4'b0010, "R6 first edge");
    clr_valid = 1'b1; clr_mask = 4'b0010;
    @(negedge clk); clr_valid = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    check(stat, 4'b0000, "R6 no retrigger");
    bus_strobe = 1'b0;
  endtask

  task automatic t_clear;
    access(BASE + 32'h00, 1'b1);
    access(BASE + 32'h10, 1'b1);
    clear(4'b0001); check(stat, 4'b0100, "R7 partial clear");
    repeat (2) @(negedge clk); check(stat, 4'b0100, "R7 sticky");
    clear(4'hF);
  endtask

  task automatic t_irq_enable;
    cfg_irq_en = 4'b0001; cfg_line_sel = 2'd2;
    access(BASE + 32'h18, 1'b1);
    check(stat, 4'b1000, "R8 disabled slot sets status");
    check(irq_out, 4'b0000, "R8 no irq when disabled");
    access(BASE + 32'h00, 1'b1);
    check(irq_out, 4'b0100, "R8 irq when enabled");
    clear(4'b0001); check(irq_out, 4'b0000, "R8 irq drops after clear");
    clear(4'hF);
  endtask

  task automatic t_line_sel;
    cfg_irq_en = 4'hF; cfg_line_sel = 2'd0;
    access(BASE + 32'h08, 1'b0);
    check(irq_out, 4'b0001, "R9 line 0");
    @(negedge clk); cfg_line_sel = 2'd3; #1;
    check(irq_out, 4'b1000, "R9 line 3");
    clear(4'hF);
  endtask

  task automatic t_set_wins;
    access(BASE + 32'h00, 1'b1);
    @(negedge clk);
    bus_addr_hi = BASE[31:3] + 29'd2; bus_strobe = 1'b1;
    clr_valid = 1'b1; clr_mask = 4'hF;
    @(negedge clk);
    bus_strobe = 1'b0; clr_valid = 1'b0; clr_mask = '0;
    check(stat, 4'b0100, "R10 set beats clear");
    clear(4'hF);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr_hi = '0; bus_strobe = 1'b0; bus_write = 1'b0;
    cfg_base = BASE[31:5]; cfg_mon_en = 1'b1; cfg_irq_en = '0; cfg_line_sel = '0;
    clr_valid = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_decode;
    t_window;
    t_rw;
    t_enable;
    t_edge;
    t_clear;
    t_irq_enable;
    t_line_sel;
    t_set_wins;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule